// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single read or write requests from the chip's internal side into bus cycles on an 8-bit multiplexed address/data bus. The low address byte and the data share the same pins, and the high address byte has its own outputs. Each cycle has four phases of one clock each: the address phase, a turnaround phase, the data phase and a closing idle phase. In the closing idle phase the block pulses its ready output.

An 8-bit control register sets how the strobes look. In standard form, the address strobe and the data strobe are active-low pulses and a read/write level marks the direction. In latch-enable form, the address pin becomes a high-true latch pulse, the data strobe becomes a read output enable, and the read/write pin becomes a write enable. A second data strobe can take over the data-strobe pulse for the lower half of the address space. A toggle option makes the bus run its waveform during internal accesses when memory protection is off. Writes to the register never change a bus cycle that is already running.

Top module: `xbus_seq`

## Requirements
- R1: During and straight after reset, the control register reads 0x80. The address strobe, the data strobe, the second data strobe and the read/write pin are all 1. The bus output enable and ready are 0.
- R2: A control write stores bits 6, 5, 4, 2 and 1. Bit 6 selects latch-enable form, bit 5 enables the second strobe, bit 4 is the address-pin function flag, bit 2 is the internal toggle, and bit 1 is the drive select. Readback is 1 in bit 7 and 0 in bits 3 and 0, so writing 0xFF reads back 0xF6. Bits 4 and 1 appear on the two flag outputs.
- R3: A control write made in an idle cycle is visible from the next cycle. A write made during a bus cycle leaves the register unchanged until the cycle is over. It then takes effect one cycle after the first idle cycle that follows.
- R4: A request seen in an idle cycle starts the address phase in the next cycle. Ready is high for exactly one cycle, four cycles after the request is accepted. A request is accepted only in the idle state, so the next request waits at least one further cycle.
- R5: In standard form on a read, the address strobe is 0 only in the address phase. The data strobe is 0 only in the data phase. The output enable is 1 only in the address phase, so it is already released before the strobe falls.
- R6: In standard form on a write, the read/write pin is 0 from the address phase through the data phase. The bus carries the write data with the output enable at 1 from the turnaround phase through the closing idle phase.
- R7: In latch-enable form, the address pin is 1 only in the address phase, while the bus carries the low address byte, and it is 0 otherwise. The data-strobe pin is 0 only in the data phase of a read.
- R8: In latch-enable form on a write, the read/write pin is 0 only in the data phase. The data-strobe pin stays 1 for the whole write.
- R9: For an external read, the read data output shows the bus value sampled at the end of the data phase. It is valid together with ready and keeps that value until the next external read ends.
- R10: With the second-strobe enable at 0, the data-strobe pulse of an external access appears on the data strobe, and the second data strobe stays 1.
- R11: With the second-strobe enable at 1 and address bit 15 at 0 (the lower block), the data-strobe pulse appears on the second data strobe, and the data strobe stays 1 for the whole cycle.
- R12: With the second-strobe enable at 1 and address bit 15 at 1 (the upper block), the second data strobe stays 1 for the whole cycle, and the pulse appears on the data strobe.
- R13: An internal access leaves every bus pin at its previous level unless the toggle bit is 1 and the protection input is 0 when the access is accepted. When the bus does toggle, all pins follow the external waveform, except that the data strobe stays 1.
- R14: For an access that drives the bus, the high-address outputs carry address bits 15..8 from the address phase until the next driven access. The low bus byte keeps its last driven value whenever nothing drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_en | input | 1 | Internal memory protection active; blocks toggling on internal accesses |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Control register readback |
| cfg_as_alt | output | 1 | Address-pin function flag (bit 4) for the pin multiplexer |
| cfg_drive_hi | output | 1 | Drive select (bit 1) for the pad ring |
| req | input | 1 | Access request, held until ready |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = external memory, 0 = internal memory |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data of the last external read |
| ad_o | output | 8 | Multiplexed bus, outgoing value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_i | input | 8 | Multiplexed bus, incoming value |
| ahi_o | output | 8 | High address byte |
| as_o | output | 1 | Address strobe, or latch enable in latch-enable form |
| ds_o | output | 1 | Data strobe, or read output enable in latch-enable form |
| ds2_o | output | 1 | Second data strobe |
| rw_o | output | 1 | Read/write level, or write enable in latch-enable form |

## Verification
A wrong phase register shows on the strobe pins and on the bus enable in the very cycle it goes wrong, because the pins are decoded straight from the phase. A bad latched address bit 15 or a bad block-select path shows up at once as a strobe on the wrong pin. A wrong latched direction or toggle decision shows up within the same access. A pending control write that is lost or applied too early shows on the readback one cycle after the idle cycle in which it should have been applied. Read data captured at the wrong time shows on the read data output in the same cycle as ready.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
// Assumes an 8-bit control register with fixed field positions.
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_DATA = 3'd3,
        PH_DONE = 3'd4
    } phase_t;

    typedef struct packed {
        logic mode_alt;
        logic ds2_en;
        logic as_alt;
        logic ext_tog;
        logic drive_hi;
    } ctl_t;

    localparam int BIT_MODE = 6;
    localparam int BIT_DS2  = 5;
    localparam int BIT_ASF  = 4;
    localparam int BIT_TOG  = 2;
    localparam int BIT_DRV  = 1;
    localparam logic [7:0] CTL_RESET = 8'h80;

    function automatic ctl_t ctl_unpack(input logic [7:0] v);
        ctl_t c;
        c.mode_alt = v[BIT_MODE];
        c.ds2_en   = v[BIT_DS2];
        c.as_alt   = v[BIT_ASF];
        c.ext_tog  = v[BIT_TOG];
        c.drive_hi = v[BIT_DRV];
        return c;
    endfunction

    function automatic logic [7:0] ctl_pack(input ctl_t c);
        logic [7:0] v;
        v = 8'h80;
        v[BIT_MODE] = c.mode_alt;
        v[BIT_DS2]  = c.ds2_en;
        v[BIT_ASF]  = c.as_alt;
        v[BIT_TOG]  = c.ext_tog;
        v[BIT_DRV]  = c.drive_hi;
        return v;
    endfunction

endpackage

// File: rtl/xbus_ctl.sv
// Control register with a one-entry pending slot.
// A write arriving while a bus cycle runs is parked and applied in the
// next idle cycle, so the strobe format never changes mid-cycle.
module xbus_ctl
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctl_t       ctl,
    output logic [7:0] ctl_q
);

    logic       pend_v;
    logic [7:0] pend_d;

    // Register update: direct in idle, parked while a cycle runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl    <= ctl_unpack(CTL_RESET);
            pend_v <= 1'b0;
            pend_d <= 8'h00;
        end else if (idle) begin
            if (wr_en) begin
                ctl <= ctl_unpack(wr_data);
            end else if (pend_v) begin
                ctl <= ctl_unpack(pend_d);
            end
            pend_v <= 1'b0;
        end else if (wr_en) begin
            pend_d <= wr_data;
            pend_v <= 1'b1;
        end
    end

    // Readback with reserved bits at their fixed levels.
    always_comb begin
        ctl_q = ctl_pack(ctl);
    end

endmodule

// File: rtl/xbus_fsm.sv
// Bus-cycle sequencer: accepts one request in idle, steps through the
// address, turnaround, data and closing phases (one clock each), latches
// the request, and captures read data at the end of the data phase.
// Assumes the requester holds req until rdy.
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int AD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    input  logic              tog_ok,
    input  logic [AD_W-1:0]   bus_in,
    output phase_t            st,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [AD_W-1:0]   lat_wdata,
    output logic              lat_wr,
    output logic              lat_ext,
    output logic              lat_act,
    output logic [AD_W-1:0]   rdata,
    output logic              rdy
);

    phase_t st_nx;

    // Next phase: fixed one-clock steps once a request is taken.
    always_comb begin
        unique case (st)
            PH_IDLE: st_nx = req ? PH_ADDR : PH_IDLE;
            PH_ADDR: st_nx = PH_TURN;
            PH_TURN: st_nx = PH_DATA;
            PH_DATA: st_nx = PH_DONE;
            default: st_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PH_IDLE;
        else        st <= st_nx;
    end

    // Request latch, taken when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            lat_ext   <= 1'b0;
            lat_act   <= 1'b0;
        end else if (st == PH_IDLE && req) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_wr    <= req_wr;
            lat_ext   <= req_ext;
            lat_act   <= req_ext | tog_ok;
        end
    end

    // Read data capture on the closing edge of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (st == PH_DATA && lat_ext && !lat_wr) begin
            rdata <= bus_in;
        end
    end

    // Completion pulse during the closing phase.
    always_comb begin
        rdy = (st == PH_DONE);
    end

endmodule

// File: rtl/xbus_pins.sv
// Pin decoder: forms the strobes, direction line, bus enable and bus
// values from the phase and the latched request. Bus values are held in
// registers so undriven pins keep their last level.
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int AD_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  phase_t                 st,
    input  logic                   mode_alt,
    input  logic                   ds2_en,
    input  logic [ADDR_W-1:0]      lat_addr,
    input  logic [AD_W-1:0]        lat_wdata,
    input  logic                   lat_wr,
    input  logic                   lat_ext,
    input  logic                   lat_act,
    output logic [AD_W-1:0]        ad_o,
    output logic                   ad_oe,
    output logic [ADDR_W-AD_W-1:0] ahi_o,
    output logic                   as_o,
    output logic                   ds_o,
    output logic                   ds2_o,
    output logic                   rw_o
);

    localparam int HI_W = ADDR_W - AD_W;

    logic [AD_W-1:0] ad_hold;
    logic [HI_W-1:0] ahi_hold;
    logic            live, in_addr, in_data, wdrive, strobe, upper;

    // Phase qualifiers for a cycle that drives the bus.
    always_comb begin
        live    = lat_act && (st != PH_IDLE);
        in_addr = live && (st == PH_ADDR);
        in_data = live && (st == PH_DATA);
        wdrive  = live && lat_wr &&
                  (st == PH_TURN || st == PH_DATA || st == PH_DONE);
        strobe  = in_data && (!mode_alt || !lat_wr);
        upper   = lat_addr[ADDR_W-1];
    end

    // Strobe and direction pins.
    always_comb begin
        ds_o  = !(strobe && lat_ext && (!ds2_en || upper));
        ds2_o = !(strobe && ds2_en && !upper);
        as_o  = mode_alt ? in_addr : !in_addr;
        rw_o  = mode_alt ? !(in_data && lat_wr)
                         : !(live && lat_wr && st != PH_DONE);
    end

    // Bus values, falling back to the held levels.
    always_comb begin
        ad_oe = in_addr || wdrive;
        if (in_addr)     ad_o = lat_addr[AD_W-1:0];
        else if (wdrive) ad_o = lat_wdata;
        else             ad_o = ad_hold;
        ahi_o = live ? lat_addr[ADDR_W-1:AD_W] : ahi_hold;
    end

    // Hold registers track the last level on the bus pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_hold  <= '0;
            ahi_hold <= '0;
        end else begin
            ad_hold  <= ad_o;
            ahi_hold <= ahi_o;
        end
    end

endmodule

// File: rtl/xbus_seq.sv
// Top of the multiplexed external bus controller: control register,
// cycle sequencer and pin decoder. Assumes one outstanding request.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int AD_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prot_en,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_q,
    output logic                   cfg_as_alt,
    output logic                   cfg_drive_hi,
    input  logic                   req,
    input  logic                   req_wr,
    input  logic                   req_ext,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [AD_W-1:0]        req_wdata,
    output logic                   rdy,
    output logic [AD_W-1:0]        rdata,
    output logic [AD_W-1:0]        ad_o,
    output logic                   ad_oe,
    input  logic [AD_W-1:0]        ad_i,
    output logic [ADDR_W-AD_W-1:0] ahi_o,
    output logic                   as_o,
    output logic                   ds_o,
    output logic                   ds2_o,
    output logic                   rw_o
);

    ctl_t              ctl;
    phase_t            st;
    logic [ADDR_W-1:0] lat_addr;
    logic [AD_W-1:0]   lat_wdata;
    logic              lat_wr, lat_ext, lat_act, tog_ok, upper_blk;

    // Toggle permission and block select seen by the other parts.
    always_comb begin
        tog_ok       = ctl.ext_tog && !prot_en;
        upper_blk    = lat_addr[ADDR_W-1];
        cfg_as_alt   = ctl.as_alt;
        cfg_drive_hi = ctl.drive_hi;
    end

    xbus_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (st == PH_IDLE),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctl     (ctl),
        .ctl_q   (cfg_q)
    );

    xbus_fsm #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_ext   (req_ext),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tog_ok    (tog_ok),
        .bus_in    (ad_i),
        .st        (st),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_wr    (lat_wr),
        .lat_ext   (lat_ext),
        .lat_act   (lat_act),
        .rdata     (rdata),
        .rdy       (rdy)
    );

    xbus_pins #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .mode_alt  (ctl.mode_alt),
        .ds2_en    (ctl.ds2_en),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_wr    (lat_wr),
        .lat_ext   (lat_ext),
        .lat_act   (lat_act),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .ahi_o     (ahi_o),
        .as_o      (as_o),
        .ds_o      (ds_o),
        .ds2_o     (ds2_o),
        .rw_o      (rw_o)
    );

endmodule

// File: rtl/xbus_chk.sv
// Assertion checker for xbus_seq, attached by bind below.
module xbus_chk
    import xbus_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_t     st,
    input logic       lat_wr,
    input logic       lat_ext,
    input logic       upper_blk,
    input logic [7:0] cfg_q,
    input logic       rdy,
    input logic       ds_o,
    input logic       ds2_o,
    input logic       ad_oe
);

    // R4: ready lasts a single cycle.
    p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R4: the address phase is always followed by the turnaround.
    p_addr_to_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_ADDR) |=> (st == PH_TURN));

    // R3: the control register is frozen while a cycle runs.
    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE) |=> $stable(cfg_q));

    // R5: the bus is released during the data phase of a read.
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_DATA && !lat_wr) |-> !ad_oe);

    // R11: the two data strobes are never low together.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o || ds2_o));

    // R12: the second strobe stays high for the upper block.
    p_upper_ds2_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE && upper_blk) |-> ds2_o);

    // R13: the primary strobe stays high on internal accesses.
    p_internal_ds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE && !lat_ext) |-> ds_o);

endmodule

bind xbus_seq xbus_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .lat_wr    (lat_wr),
    .lat_ext   (lat_ext),
    .upper_blk (upper_blk),
    .cfg_q     (cfg_q),
    .rdy       (rdy),
    .ds_o      (ds_o),
    .ds2_o     (ds2_o),
    .ad_oe     (ad_oe)
);

// File: tb/test_xbus_seq.sv
// Bench for xbus_seq: behavioural reference model compared every clock.
module test_xbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        req = 1'b0, req_wr = 1'b0, req_ext = 1'b0;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  req_wdata = 8'h00;
    logic [7:0]  ad_i = 8'h00;
    logic [7:0]  cfg_q, rdata, ad_o, ahi_o;
    logic        cfg_as_alt, cfg_drive_hi, rdy, ad_oe, as_o, ds_o, ds2_o, rw_o;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xbus_seq i_xbus_seq (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .cfg_as_alt(cfg_as_alt), .cfg_drive_hi(cfg_drive_hi),
        .req(req), .req_wr(req_wr), .req_ext(req_ext),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rdy(rdy), .rdata(rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .ahi_o(ahi_o), .as_o(as_o), .ds_o(ds_o), .ds2_o(ds2_o), .rw_o(rw_o)
    );

    // ---------------- reference model ----------------
    int          m_ph;        // 0 idle, 1 address, 2 turnaround, 3 data, 4 closing
    logic [7:0]  m_cfg, m_pend, m_rdata, m_adh, m_ahih;
    bit          m_pv;
    logic [15:0] m_addr;
    logic [7:0]  m_wd;
    bit          m_wr, m_ext, m_act;
    logic        e_as, e_ds, e_ds2, e_rw, e_oe;
    logic [7:0]  e_ad, e_ahi;

    function automatic logic [7:0] cfg_mask(input logic [7:0] v);
        return {1'b1, v[6:4], 1'b0, v[2:1], 1'b0};
    endfunction

    // Expected pin levels for the current model state.
    task automatic model_pins();
        bit alt, two, driven;
        alt = m_cfg[6];
        two = m_cfg[5];
        driven = (m_ph != 0) && m_act;
        e_as = alt ? 1'b0 : 1'b1;
        e_ds = 1'b1; e_ds2 = 1'b1; e_rw = 1'b1; e_oe = 1'b0;
        e_ad = m_adh; e_ahi = m_ahih;
        if (driven) begin
            e_ahi = m_addr[15:8];
            case (m_ph)
                1: begin
                    e_as = alt ? 1'b1 : 1'b0;
                    e_ad = m_addr[7:0];
                    e_oe = 1'b1;
                    if (!alt && m_wr) e_rw = 1'b0;
                end
                2: if (m_wr) begin
                    e_oe = 1'b1; e_ad = m_wd;
                    if (!alt) e_rw = 1'b0;
                end
                3: begin
                    if (m_wr) begin e_oe = 1'b1; e_ad = m_wd; e_rw = 1'b0; end
                    if (!alt || !m_wr) begin
                        if (two && !m_addr[15]) e_ds2 = 1'b0;
                        else if (m_ext)         e_ds  = 1'b0;
                    end
                end
                default: if (m_wr) begin e_oe = 1'b1; e_ad = m_wd; end
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cfg = 8'h80; m_pend = 8'h00; m_pv = 0;
            m_rdata = 8'h00; m_adh = 8'h00; m_ahih = 8'h00;
            m_addr = 16'h0; m_wd = 8'h0; m_wr = 0; m_ext = 0; m_act = 0;
        end else begin
            model_pins();
            m_adh = e_ad;
            m_ahih = e_ahi;
            if (m_ph == 3 && m_ext && !m_wr) m_rdata = ad_i;
            if (m_ph == 0) begin
                if (req) begin
                    m_addr = req_addr; m_wd = req_wdata; m_wr = req_wr;
                    m_ext = req_ext;
                    m_act = req_ext || (m_cfg[2] && !prot_en);
                    m_ph = 1;
                end
                if (cfg_we)    m_cfg = cfg_mask(cfg_wdata);
                else if (m_pv) m_cfg = m_pend;
                m_pv = 0;
            end else begin
                if (cfg_we) begin m_pend = cfg_mask(cfg_wdata); m_pv = 1; end
                m_ph = (m_ph == 4) ? 0 : m_ph + 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (chk_on && !done) begin
            string t_as, t_rw, t_ds, t_bus;
            bit internal_live;
            model_pins();
            internal_live = (m_ph != 0) && !m_ext && m_act;
            t_as = m_cfg[6] ? "R7" : "R5";
            t_rw = m_cfg[6] ? "R8" : "R6";
            if (m_ph != 0 && !m_ext)      t_ds = "R13";
            else if (!m_cfg[5])           t_ds = "R10";
            else if (m_addr[15])          t_ds = "R12";
            else                          t_ds = "R11";
            t_bus = "R14";
            if (internal_live || (m_ph != 0 && !m_act)) begin
                t_as = "R13"; t_rw = "R13"; t_bus = "R13";
            end
            chk("R2", "cfg_q", cfg_q, m_cfg);
            chk("R2", "cfg_as_alt", cfg_as_alt, m_cfg[4]);
            chk("R2", "cfg_drive_hi", cfg_drive_hi, m_cfg[1]);
            chk("R4", "rdy", rdy, (m_ph == 4));
            chk("R9", "rdata", rdata, m_rdata);
            chk(t_as, "as_o", as_o, e_as);
            chk(t_rw, "rw_o", rw_o, e_rw);
            chk(t_ds, "ds_o", ds_o, e_ds);
            chk(t_ds, "ds2_o", ds2_o, e_ds2);
            chk(t_rw, "ad_oe", ad_oe, e_oe);
            chk(t_bus, "ad_o", ad_o, e_ad);
            chk(t_bus, "ahi_o", ahi_o, e_ahi);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit wr, input bit ext, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] bus_val);
        int lat;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_ext = ext; req_addr = a;
        req_wdata = wd; ad_i = bus_val;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rdy && lat < 20);
        req = 1'b0;
        chk("R4", "ready latency", lat, 4);
        if (!wr && ext) chk("R9", "read data", rdata, bus_val);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired R4 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cfg_q reset", cfg_q, 8'h80);
        chk("R1", "as_o reset", as_o, 1);
        chk("R1", "ds_o reset", ds_o, 1);
        chk("R1", "ds2_o reset", ds2_o, 1);
        chk("R1", "rw_o reset", rw_o, 1);
        chk("R1", "ad_oe reset", ad_oe, 0);
        chk("R1", "rdy reset", rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        chk("R1", "cfg_q after reset", cfg_q, 8'h80);

        // R5 R9 R10 R6 R14: standard form, single strobe
        access(0, 1, 16'h1234, 8'h00, 8'hC3);
        access(1, 1, 16'h2345, 8'h5A, 8'h00);
        access(0, 1, 16'hA1B2, 8'h00, 8'h3C);

        // R2: reserved bits masked
        cfg_write(8'hFF);
        chk("R2", "masked readback", cfg_q, 8'hF6);
        chk("R2", "flag outputs", {cfg_as_alt, cfg_drive_hi}, 2'b11);

        // R11 R12: second strobe split
        cfg_write(8'h20);
        access(0, 1, 16'h0456, 8'h00, 8'h77);
        access(0, 1, 16'h9A10, 8'h00, 8'h88);
        access(1, 1, 16'hF00F, 8'h99, 8'h00);
        access(1, 1, 16'h7001, 8'h11, 8'h00);

        // R7 R8: latch-enable form
        cfg_write(8'h40);
        access(0, 1, 16'h4321, 8'h00, 8'hE1);
        access(1, 1, 16'h5432, 8'h2D, 8'h00);
        cfg_write(8'h60);
        access(0, 1, 16'h0102, 8'h00, 8'h4B);
        access(0, 1, 16'h8203, 8'h00, 8'hB4);
        access(1, 1, 16'h0304, 8'h6E, 8'h00);

        // R13: internal accesses, quiet and toggling
        cfg_write(8'h00);
        access(0, 0, 16'h3333, 8'h00, 8'hAA);
        access(1, 0, 16'h4444, 8'h55, 8'h00);
        cfg_write(8'h04);
        prot_en = 1'b0;
        access(1, 0, 16'h5555, 8'h66, 8'h00);
        access(0, 0, 16'h1666, 8'h00, 8'h12);
        cfg_write(8'h24);
        access(0, 0, 16'h0777, 8'h00, 8'h13);
        prot_en = 1'b1;
        access(1, 0, 16'h6789, 8'h21, 8'h00);
        access(0, 1, 16'h0ABC, 8'h00, 8'h5E);
        prot_en = 1'b0;

        // R3: control write during a running cycle
        cfg_write(8'h00);
        fork
            access(0, 1, 16'h1357, 8'h00, 8'h9D);
            begin
                repeat (2) @(negedge clk);
                cfg_we = 1'b1; cfg_wdata = 8'h24;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        chk("R3", "held during cycle", cfg_q, 8'h80);
        @(negedge clk);
        chk("R3", "first idle cycle", cfg_q, 8'h80);
        @(negedge clk);
        chk("R3", "applied after cycle", cfg_q, 8'hA4);

        // R4: back-to-back requests
        access(0, 1, 16'h2468, 8'h00, 8'h42);
        access(1, 1, 16'h8642, 8'h24, 8'h00);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule